// File: doc/BRIEF.md
# Serial Frame Packetizer

The block is the transmit engine of a serial link. It turns a frame request (a frame kind and a payload length) plus a stream of payload words into one complete frame, sent as a stream of 32-bit words. Each word carries a flag that marks it as a control character. A frame has five parts, always in the same order: a start delimiter, six header words chosen from the frame kind, the payload words, a CRC-32 word over header and payload, and an end delimiter. When no frame is being sent, the output carries fill words.

Payload enters through a valid/ready handshake, and words leave through a second valid/ready handshake. The CRC is updated 32 bits per cycle as header and payload words are accepted downstream, so it adds no cycles beyond its own word. A request is taken only while the engine is between frames, and one frame is built per request.

Top module: `frame_packetizer`

## Requirements
- R1: Between frames the output presents the fill word 32'hBC95B5B5 with `out_k`=1 and `out_valid`=1, and `req_ready` is 1 only in that condition. After an end delimiter is accepted, the next word is a fill word.
- R2: After a request is accepted, the first frame word is the start delimiter 32'hBCB55656 with `out_k`=1. It is followed by exactly six header words, then the payload, then the CRC word, then the end delimiter.
- R3: Header words (all with `out_k`=0) are, in order: {R,DEST_ID}, {8'h00,SRC_ID}, {C,F}, 32'h00000000, 32'hFFFFFFFF, {16'h0000, length as 16 bits}. R is 8'h06/8'h22/8'h23/8'h84 for kinds 0/1/2/3. C is 8'h08 for kind 0 and 8'h01 otherwise. F is 24'h290000 for odd kinds and 24'h380000 for even kinds.
- R4: Payload words appear unchanged on `out_data` with `out_k`=0. During the payload phase `pl_ready` equals `out_ready`, and `out_valid` is 0 whenever `pl_valid` is 0.
- R5: The CRC word (`out_k`=0) is the ones-complement of a CRC-32 with polynomial 32'h04C11DB7 and register preset to all ones. It is computed over the header and payload words, bit 31 of each word first, with no bit reflection.
- R6: The end delimiter 32'hBC95D5D5 with `out_k`=1 is the word accepted directly after the CRC word. When `out_ready` stays high, it appears in the very next cycle.
- R7: While a frame word is presented and `out_ready` is 0, `out_data` and `out_k` hold their values, and no frame word is skipped or repeated.
- R8: A request of length 0 sends the CRC word immediately after the sixth header word.
- R9: A request with a length above MAX_WORDS is sent with MAX_WORDS payload words and that value in its header. Requests presented while a frame is in progress are ignored (`req_ready`=0) and do not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Request accepted (engine between frames) |
| req_type | input | 2 | Frame kind selecting header contents |
| req_len | input | LEN_W | Payload length in words |
| pl_valid | input | 1 | Payload word present |
| pl_ready | output | 1 | Payload word taken |
| pl_data | input | 32 | Payload word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Output word |
| out_k | output | 1 | Output word is a control character |

## Verification
If the sequencer state were wrong, the fault would show at the ports within one accepted word. Examples are a header word out of place, a missing or doubled word after a stall, or an end delimiter that does not directly follow the CRC. If the CRC register were wrong, nothing would show until the CRC word of that frame, so every frame length from 0 to the maximum is swept for all four frame kinds. Stall and gap patterns cover the hold behaviour in every phase.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  localparam logic [31:0] W_IDLE = 32'hBC95B5B5;
  localparam logic [31:0] W_SOF  = 32'hBCB55656;
  localparam logic [31:0] W_EOF  = 32'hBC95D5D5;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam int unsigned HDR_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_HDR,
    ST_PAY,
    ST_CRC,
    ST_EOF
  } pk_state_e;

  // 32-bit-per-cycle CRC step, MSB of the word first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      fb = r[31] ^ d[b];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_crc32.sv
module pkt_crc32
  import pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [31:0] din,
  output logic [31:0] crc_q
);

  logic [31:0] crc_d;
  logic        crc_en;

  always_comb begin
    crc_en = init | upd;
    crc_d  = init ? 32'hFFFFFFFF : crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= 32'hFFFFFFFF;
    else if (crc_en) crc_q <= crc_d;
  end

  // R5
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == 32'hFFFFFFFF));

endmodule

// File: rtl/pkt_hdr_gen.sv
module pkt_hdr_gen #(
  parameter logic [23:0] DEST_ID = 24'h010203,
  parameter logic [23:0] SRC_ID  = 24'h0A0B0C,
  parameter int unsigned LEN_W   = 5
) (
  input  logic [1:0]       ftype,
  input  logic [LEN_W-1:0] flen,
  input  logic [2:0]       idx,
  output logic [31:0]      word
);

  logic [7:0]  rsel;
  logic [7:0]  csel;
  logic [23:0] fsel;

  always_comb begin
    case (ftype)
      2'd0:    rsel = 8'h06;
      2'd1:    rsel = 8'h22;
      2'd2:    rsel = 8'h23;
      default: rsel = 8'h84;
    endcase
    csel = (ftype == 2'd0) ? 8'h08 : 8'h01;
    fsel = ftype[0] ? 24'h290000 : 24'h380000;
    case (idx)
      3'd0:    word = {rsel, DEST_ID};
      3'd1:    word = {8'h00, SRC_ID};
      3'd2:    word = {csel, fsel};
      3'd3:    word = 32'h00000000;
      3'd4:    word = 32'hFFFFFFFF;
      default: word = {16'h0000, 16'(flen)};
    endcase
  end

endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 16,
  parameter int unsigned LEN_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [LEN_W-1:0] req_len,
  input  logic             pl_valid,
  input  logic             out_ready,
  output pk_state_e        st_q,
  output logic [2:0]       idx_q,
  output logic [1:0]       type_q,
  output logic [LEN_W-1:0] len_q,
  output logic             out_vld,
  output logic             fire
);

  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_WORDS);
  localparam logic [2:0]       IDX_LAST = 3'(HDR_WORDS - 1);

  pk_state_e        st_d;
  logic [2:0]       idx_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       type_d;
  logic [LEN_W-1:0] len_d;
  logic             take_req;

  always_comb begin
    out_vld  = (st_q == ST_PAY) ? pl_valid : 1'b1;
    fire     = out_vld & out_ready;
    take_req = (st_q == ST_IDLE) & req_valid;
    st_d     = st_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    type_d   = type_q;
    len_d    = len_q;
    case (st_q)
      ST_IDLE: if (take_req) begin
        st_d   = ST_SOF;
        type_d = req_type;
        len_d  = (req_len > LEN_MAX) ? LEN_MAX : req_len;
      end
      ST_SOF: if (fire) begin
        st_d  = ST_HDR;
        idx_d = 3'd0;
      end
      ST_HDR: if (fire) begin
        if (idx_q == IDX_LAST) begin
          st_d  = (len_q == '0) ? ST_CRC : ST_PAY;
          cnt_d = '0;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      ST_PAY: if (fire) begin
        if (cnt_q == len_q - LEN_W'(1)) st_d = ST_CRC;
        else                            cnt_d = cnt_q + LEN_W'(1);
      end
      ST_CRC: if (fire) st_d = ST_EOF;
      ST_EOF: if (fire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= 3'd0;
      cnt_q  <= '0;
      type_q <= 2'd0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      type_q <= type_d;
      len_q  <= len_d;
    end
  end

  // R3
  hdr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> (idx_q <= IDX_LAST));

  // R9
  pay_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> (cnt_q < len_q && len_q <= LEN_MAX));

  // R9
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && req_valid) |=> ($stable(type_q) && $stable(len_q)));

endmodule

// File: rtl/frame_packetizer.sv
module frame_packetizer
  import pkt_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 16,
  parameter logic [23:0] DEST_ID   = 24'h010203,
  parameter logic [23:0] SRC_ID    = 24'h0A0B0C,
  parameter int unsigned LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [LEN_W-1:0] req_len,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [31:0]      pl_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_k
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  pk_state_e        st_q;
  logic [2:0]       idx_q;
  logic [1:0]       type_q;
  logic [LEN_W-1:0] len_q;
  logic             out_vld;
  logic             fire;
  logic [31:0]      hdr_word;
  logic [31:0]      crc_q;
  logic             crc_init;
  logic             crc_upd;
  logic [31:0]      crc_din;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pkt_seq #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req_valid (req_valid),
    .req_type  (req_type),
    .req_len   (req_len),
    .pl_valid  (pl_valid),
    .out_ready (out_ready),
    .st_q      (st_q),
    .idx_q     (idx_q),
    .type_q    (type_q),
    .len_q     (len_q),
    .out_vld   (out_vld),
    .fire      (fire)
  );

  pkt_hdr_gen #(.DEST_ID(DEST_ID), .SRC_ID(SRC_ID), .LEN_W(LEN_W)) u_hdr (
    .ftype (type_q),
    .flen  (len_q),
    .idx   (idx_q),
    .word  (hdr_word)
  );

  always_comb begin
    crc_init = (st_q == ST_SOF);
    crc_upd  = fire & ((st_q == ST_HDR) | (st_q == ST_PAY));
    crc_din  = (st_q == ST_PAY) ? pl_data : hdr_word;
  end

  pkt_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_s_n),
    .init  (crc_init),
    .upd   (crc_upd),
    .din   (crc_din),
    .crc_q (crc_q)
  );

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    pl_ready  = (st_q == ST_PAY) & out_ready;
    out_valid = out_vld;
    case (st_q)
      ST_SOF:  begin out_data = W_SOF;    out_k = 1'b1; end
      ST_HDR:  begin out_data = hdr_word; out_k = 1'b0; end
      ST_PAY:  begin out_data = pl_data;  out_k = 1'b0; end
      ST_CRC:  begin out_data = ~crc_q;   out_k = 1'b0; end
      ST_EOF:  begin out_data = W_EOF;    out_k = 1'b1; end
      default: begin out_data = W_IDLE;   out_k = 1'b1; end
    endcase
  end

  // R6
  eof_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_CRC && out_ready) |=> (out_valid && out_k && out_data == W_EOF));

  // R1
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire && out_k && out_data == W_EOF) |=> (out_valid && out_k && out_data == W_IDLE));

  // R2
  sof_then_hdr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire && out_k && out_data == W_SOF) |=> (!out_k && out_data == {hdr_word[31:24], DEST_ID}));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q != ST_IDLE && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_k)));

endmodule

// File: tb/frame_packetizer_bench.sv
`timescale 1ns/1ps
module frame_packetizer_bench;

  localparam int MAXW = 16;
  localparam int LW   = $clog2(MAXW + 1);
  localparam logic [23:0] DID = 24'h010203;
  localparam logic [23:0] SID = 24'h0A0B0C;
  localparam logic [31:0] IDLE_W = 32'hBC95B5B5;
  localparam logic [31:0] SOF_W  = 32'hBCB55656;
  localparam logic [31:0] EOF_W  = 32'hBC95D5D5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_type;
  logic [LW-1:0] req_len;
  logic          pl_valid, pl_ready;
  logic [31:0]   pl_data;
  logic          out_valid, out_ready, out_k;
  logic [31:0]   out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  frame_packetizer #(.MAX_WORDS(MAXW), .DEST_ID(DID), .SRC_ID(SID)) u_frame_packetizer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_len(req_len),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_k(out_k)
  );

  task automatic chk(input logic ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int t, input int n, input int i);
    return 32'h5A000000 ^ (32'(i) << 16) ^ (32'(n) << 8) ^ 32'(t * 17);
  endfunction

  function automatic logic [31:0] hdr(input int t, input int n, input int i);
    logic [7:0] r;
    r = (t == 0) ? 8'h06 : (t == 1) ? 8'h22 : (t == 2) ? 8'h23 : 8'h84;
    case (i)
      0: return {r, DID};
      1: return {8'h00, SID};
      2: return {((t == 0) ? 8'h08 : 8'h01), ((t % 2 == 1) ? 24'h290000 : 24'h380000)};
      3: return 32'h0;
      4: return 32'hFFFFFFFF;
      default: return {16'h0, 16'(n)};
    endcase
  endfunction

  function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] ^ w[b]) r = (r << 1) ^ 32'h04C11DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic run_frame(input int t, input int nreq, input int mode);
    logic [32:0] ex [0:63];
    logic [31:0] c;
    int nn, total, ptr, cyc, pidx, crc_cyc;
    logic stalled, pl_fire, req_flag;
    logic [32:0] prev;
    nn = (nreq > MAXW) ? MAXW : nreq;
    c = 32'hFFFFFFFF;
    ex[0] = {1'b1, SOF_W};
    for (int i = 0; i < 6; i++) begin ex[1+i] = {1'b0, hdr(t, nn, i)}; c = crc_add(c, hdr(t, nn, i)); end
    for (int i = 0; i < nn; i++) begin ex[7+i] = {1'b0, pay(t, nreq, i)}; c = crc_add(c, pay(t, nreq, i)); end
    ex[7+nn] = {1'b0, ~c};
    ex[8+nn] = {1'b1, EOF_W};
    total = 9 + nn;

    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_len = LW'(nreq); out_ready = 1'b1; pl_valid = 1'b0;
    #1 chk(req_ready, "R1 req_ready idle", {32'h0, req_ready}, 33'h1);
    @(negedge clk);
    req_valid = 1'b0;
    ptr = 0; cyc = 0; pidx = 0; crc_cyc = -10; stalled = 1'b0; prev = '0; req_flag = 1'b0;
    while (ptr < total && cyc < 2000) begin
      out_ready = (mode == 0) ? 1'b1 : (((cyc * 5 + mode) % 3) != 0);
      if (!pl_valid) pl_valid = (mode == 0) ? 1'b1 : ((cyc % 4) != 2);
      pl_data = pay(t, nreq, pidx);
      if (mode == 2) begin req_valid = 1'b1; req_type = ~2'(t); req_len = LW'(3); end
      #1;
      if (mode == 2 && !req_flag) begin
        chk(!req_ready, "R9 req blocked busy", {32'h0, req_ready}, 33'h0);
        req_flag = 1'b1;
      end
      if (stalled && out_valid)
        chk({out_k, out_data} == prev, "R7 hold on stall", {out_k, out_data}, prev);
      if (ptr >= 7 && ptr < 7 + nn) begin
        if (!pl_valid) chk(!out_valid, "R4 gap stalls output", {32'h0, out_valid}, 33'h0);
        chk(pl_ready == out_ready, "R4 pl_ready follows out_ready", {32'h0, pl_ready}, {32'h0, out_ready});
      end
      if (out_valid && out_ready) begin
        if (ptr == 0)            chk({out_k, out_data} == ex[ptr], "R2 start delimiter", {out_k, out_data}, ex[ptr]);
        else if (ptr < 7)        chk({out_k, out_data} == ex[ptr], (nreq > MAXW) ? "R9 clamped header" : "R3 header word", {out_k, out_data}, ex[ptr]);
        else if (ptr < 7 + nn)   chk({out_k, out_data} == ex[ptr], "R4 payload word", {out_k, out_data}, ex[ptr]);
        else if (ptr == 7 + nn) begin
          chk({out_k, out_data} == ex[ptr], (nn == 0) ? "R8 crc after header" : "R5 crc word", {out_k, out_data}, ex[ptr]);
          crc_cyc = cyc;
        end else begin
          chk({out_k, out_data} == ex[ptr], "R6 end delimiter", {out_k, out_data}, ex[ptr]);
          if (mode == 0) chk(cyc == crc_cyc + 1, "R6 eof next cycle", 33'(cyc), 33'(crc_cyc + 1));
        end
        ptr++;
      end
      stalled = out_valid && !out_ready;
      prev = {out_k, out_data};
      pl_fire = pl_valid && pl_ready;
      @(negedge clk);
      cyc++;
      if (pl_fire) begin pidx++; pl_valid = 1'b0; end
    end
    req_valid = 1'b0; pl_valid = 1'b0; out_ready = 1'b1;
    chk(ptr == total, "R2 frame complete", 33'(ptr), 33'(total));
    for (int k = 0; k < 2; k++) begin
      #1 chk(out_valid && out_k && out_data == IDLE_W && req_ready, "R1 fill word after frame",
             {out_k, out_data}, {1'b1, IDLE_W});
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_type = 2'd0; req_len = '0;
    pl_valid = 1'b0; pl_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid && out_k && out_data == IDLE_W, "R1 reset fill word", {out_k, out_data}, {1'b1, IDLE_W});
    chk(req_ready && !pl_ready, "R1 reset handshakes", {31'h0, req_ready, pl_ready}, 33'h2);
    for (int t = 0; t < 4; t++)
      for (int n = 0; n <= MAXW; n++)
        run_frame(t, n, (t + n) % 3);
    run_frame(1, MAXW + 4, 0);   // R9 clamp
    run_frame(2, 0, 1);          // R8 zero length under stalls
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule